// File: doc/BRIEF.md
# Endpoint Interrupt Request Sequencer

This block drives the interrupt request path from an endpoint's logic toward a PCIe core's configuration-side interrupt handshake. An internal event pulse starts a request. The request is an active-low strobe, and the strobe is held until the core answers with an active-low ready.

The event is handled in one of two ways, chosen by the core's MSI enable at the moment the block starts:

- **MSI enabled:** the event becomes one message request that carries a data byte.
- **MSI disabled (legacy mode):** the event becomes a pair of requests. The first request asserts the virtual INTx line. The block then holds the line asserted. It sends the deasserting request only after software sets a clear bit in the control register. That bit clears itself once the deassert handshake completes.

Events that arrive while a sequence is in progress are stored as one pending request. The block services the pending request after it returns to idle.

The control register is reached through a simple word-indexed write/read port. It holds the outgoing data byte and the clear bit. It also reflects the core's MSI enable, multiple-message enable and returned data byte.

Top module: `intx_msi_sequencer`

## Requirements
- R1: After reset (rst_n low, synchronous), irq_req_n and irq_assert_n are high, and a read of index 18 with all core inputs at zero returns 0.
- R2: A write to word index 18 loads the data byte from wdata[7:0] and the clear bit from wdata[8]. A write to any other index leaves index 18 unchanged. A read of any other index returns 0.
- R3: A read of index 18 returns these fields:
  - [7:0]: the data byte
  - [8]: the clear bit
  - [23:16]: core_vec_out
  - [26:24]: core_mm_en
  - [27]: core_msi_en
  - all other bits: zero
- R4: With core_msi_en low, an event sampled in idle makes irq_req_n low with irq_assert_n low from the next cycle. The request stays low and unchanged until irq_rdy_n is sampled low on a rising edge.
- R5: After the assert handshake, no request is raised while the clear bit is 0. Once the clear bit is 1, a request with irq_assert_n high (deassert) is raised.
- R6: The clear bit reads back as 0 after the deassert handshake completes.
- R7: With core_msi_en high, an event produces exactly one request, with irq_assert_n high and irq_data equal to the data byte. No second request follows.
- R8: After any handshake (irq_rdy_n sampled low while irq_req_n is low), irq_req_n is high for at least the next cycle.
- R9: An event that arrives while a sequence is in progress is held as pending. A new sequence for it starts one cycle after the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_event | input | 1 | One-cycle interrupt event from endpoint logic |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| core_msi_en | input | 1 | MSI enable reported by the core |
| core_mm_en | input | 3 | Multiple-message enable reported by the core |
| core_vec_out | input | 8 | Interrupt data byte returned by the core |
| irq_rdy_n | input | 1 | Active-low ready from the core |
| irq_req_n | output | 1 | Active-low interrupt request |
| irq_assert_n | output | 1 | Low for an INTx assert request, high for deassert or MSI |
| irq_data | output | 8 | Data byte sent with the request |

## Verification
The assertions take two things for granted about the core:

- it pulls irq_rdy_n low only while a request is outstanding;
- it keeps core_msi_en steady across a sequence.

A stray ready in idle would otherwise look like a completed handshake to an observer. The mode is sampled only at the start, so a mid-sequence change of core_msi_en has no effect on the block, but the property that a request stays unchanged assumes the same. The stimulus drives irq_rdy_n low for exactly one cycle, and only while irq_req_n is low. It changes core_msi_en only while the block is idle, and it pulses irq_event for a single cycle at a time.

// File: rtl/irq_seq_pkg.sv
// Package: shared state encoding for the interrupt sequencer.
// Assumes nothing beyond being compiled before the modules that import it.
package irq_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ASRT_REQ = 3'd1,
        ST_HELD     = 3'd2,
        ST_DEAS_REQ = 3'd3,
        ST_MSI_REQ  = 3'd4
    } irq_state_e;
endpackage

// File: rtl/irq_ctrl_regs.sv
// Module: irq_ctrl_regs
// Holds the interrupt control word: the outgoing data byte and the
// software-set clear bit. The clear bit drops when the sequencer reports a
// finished deassert handshake. The read side mirrors the core's MSI fields.
// Assumes a word-indexed, single-cycle write port. A write in the same cycle
// as clear_done takes priority.
module irq_ctrl_regs #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 7,
    parameter int CTRL_IDX = 18,
    parameter int VEC_W    = 8,
    parameter int MM_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clear_done,
    input  logic              core_msi_en,
    input  logic [MM_W-1:0]   core_mm_en,
    input  logic [VEC_W-1:0]  core_vec_out,
    output logic [DATA_W-1:0] rdata,
    output logic [VEC_W-1:0]  vec_in,
    output logic              clear_req
);
    localparam int CLR_BIT = VEC_W;
    localparam int OUT_LSB = 16;
    localparam int MM_LSB  = OUT_LSB + VEC_W;
    localparam int MSI_BIT = MM_LSB + MM_W;

    logic hit;
    logic ctrl_wr;
    logic unused_wdata;

    // Decode of the control register index.
    assign hit          = (addr == ADDR_W'(CTRL_IDX));
    assign ctrl_wr      = wr_en && hit;
    assign unused_wdata = ^wdata[DATA_W-1:CLR_BIT+1];

    // Data byte and clear bit storage, with self-clear on deassert completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_in    <= '0;
            clear_req <= 1'b0;
        end else if (ctrl_wr) begin
            vec_in    <= wdata[VEC_W-1:0];
            clear_req <= wdata[CLR_BIT];
        end else if (clear_done) begin
            clear_req <= 1'b0;
        end
    end

    // Read-back assembly of the control word; other indices read as zero.
    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[VEC_W-1:0]        = vec_in;
            rdata[CLR_BIT]          = clear_req;
            rdata[OUT_LSB +: VEC_W] = core_vec_out;
            rdata[MM_LSB +: MM_W]   = core_mm_en;
            rdata[MSI_BIT]          = core_msi_en;
        end
    end

    // R6: a finished deassert with no concurrent write leaves the bit cleared.
    assert_clear_self_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_done && !ctrl_wr) |=> !clear_req);

    // R2: writes elsewhere leave the data byte untouched.
    assert_other_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> $stable(vec_in));
endmodule

// File: rtl/irq_pend_latch.sv
// Module: irq_pend_latch
// Remembers one event that arrives while the sequencer is busy, until the
// sequencer takes it from idle. Further events while one is pending merge
// into it.
module irq_pend_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic busy,
    input  logic take,
    output logic pend
);
    // Set on a busy-time event, drop when the idle state consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (evt && busy)
            pend <= 1'b1;
        else if (take)
            pend <= 1'b0;
    end
endmodule

// File: rtl/irq_handshake_fsm.sv
// Module: irq_handshake_fsm
// Sequences requests to the core.
// - MSI mode: a single request.
// - Legacy mode: an assert request, a hold until software clear, then a
//   deassert request.
// The mode is sampled when a sequence starts. Outputs decode straight from
// the state register, so a request always drops for at least one cycle
// after a handshake.
// Assumes ready is only pulled low while a request is outstanding.
module irq_handshake_fsm
    import irq_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic msi_mode,
    input  logic clear_req,
    input  logic rdy_n,
    output logic req_n,
    output logic assert_n,
    output logic busy,
    output logic take,
    output logic clear_done
);
    irq_state_e state, state_nx;
    logic hs;

    // Handshake completes when the core's ready is seen during a request.
    assign hs         = !req_n && !rdy_n;
    assign take       = (state == ST_IDLE) && start;
    assign busy       = (state != ST_IDLE);
    assign clear_done = (state == ST_DEAS_REQ) && !rdy_n;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:     if (start) state_nx = msi_mode ? ST_MSI_REQ : ST_ASRT_REQ;
            ST_ASRT_REQ: if (!rdy_n) state_nx = ST_HELD;
            ST_HELD:     if (clear_req) state_nx = ST_DEAS_REQ;
            ST_DEAS_REQ: if (!rdy_n) state_nx = ST_IDLE;
            ST_MSI_REQ:  if (!rdy_n) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Output decode from the registered state.
    always_comb begin
        req_n    = !((state == ST_ASRT_REQ) || (state == ST_DEAS_REQ) ||
                     (state == ST_MSI_REQ));
        assert_n = (state != ST_ASRT_REQ);
    end

    // R4: an unanswered request stays outstanding.
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && rdy_n) |=> !req_n);

    // R4: the assert flag does not change under an outstanding request.
    assert_flag_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && rdy_n) |=> $stable(assert_n));

    // R8: every handshake is followed by a released request.
    assert_gap_after_hs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hs |=> req_n);

    // R5: the held line is not released without the clear bit.
    assert_hold_until_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && !clear_req) |=> (state == ST_HELD));
endmodule

// File: rtl/intx_msi_sequencer.sv
// Module: intx_msi_sequencer (top)
// Connects the control register, the pending-event latch and the handshake
// sequencer. The data byte sent with a request is the register's data byte.
// Assumes the core holds core_msi_en steady during a sequence.
module intx_msi_sequencer #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 7,
    parameter int CTRL_IDX = 18,
    parameter int VEC_W    = 8,
    parameter int MM_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_event,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              core_msi_en,
    input  logic [MM_W-1:0]   core_mm_en,
    input  logic [VEC_W-1:0]  core_vec_out,
    input  logic              irq_rdy_n,
    output logic              irq_req_n,
    output logic              irq_assert_n,
    output logic [VEC_W-1:0]  irq_data
);
    logic clear_req, clear_done, busy, take, pend, start;

    assign start = irq_event || pend;

    irq_ctrl_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_IDX(CTRL_IDX),
        .VEC_W(VEC_W), .MM_W(MM_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .clear_done(clear_done), .core_msi_en(core_msi_en),
        .core_mm_en(core_mm_en), .core_vec_out(core_vec_out),
        .rdata(reg_rdata), .vec_in(irq_data), .clear_req(clear_req)
    );

    irq_pend_latch u_pend (
        .clk(clk), .rst_n(rst_n), .evt(irq_event), .busy(busy),
        .take(take), .pend(pend)
    );

    irq_handshake_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .msi_mode(core_msi_en),
        .clear_req(clear_req), .rdy_n(irq_rdy_n), .req_n(irq_req_n),
        .assert_n(irq_assert_n), .busy(busy), .take(take),
        .clear_done(clear_done)
    );
endmodule

// File: tb/intx_msi_sequencer_tb.sv
`timescale 1ns/1ps
module intx_msi_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_event = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [6:0]  reg_addr = 7'd18;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        core_msi_en = 1'b0;
    logic [2:0]  core_mm_en = '0;
    logic [7:0]  core_vec_out = '0;
    logic        irq_rdy_n = 1'b1;
    logic        irq_req_n, irq_assert_n;
    logic [7:0]  irq_data;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    intx_msi_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .irq_event(irq_event), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .core_msi_en(core_msi_en), .core_mm_en(core_mm_en),
        .core_vec_out(core_vec_out), .irq_rdy_n(irq_rdy_n),
        .irq_req_n(irq_req_n), .irq_assert_n(irq_assert_n), .irq_data(irq_data)
    );

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL watchdog all-reqs act=hung exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr_en = 1'b0; reg_addr = 7'd18;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 7'd18;
    endtask

    task automatic pulse();
        irq_event = 1'b1; tick(); irq_event = 1'b0;
    endtask

    task automatic handshake();
        irq_rdy_n = 1'b0; tick(); irq_rdy_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 req_n", {31'd0, irq_req_n}, 32'd1);
        chk("R1 assert_n", {31'd0, irq_assert_n}, 32'd1);
        rd(7'd18, d);
        chk("R1 reg", d, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(7'd18, 32'hFFFF_FE3C);
        rd(7'd18, d);
        chk("R2 write data/clear=0", d, 32'h0000_003C);
        wr(7'd17, 32'hFFFF_FFFF);
        rd(7'd18, d);
        chk("R2 other index ignored", d, 32'h0000_003C);
        rd(7'd17, d);
        chk("R2 other index reads 0", d, 32'd0);
    endtask

    task automatic t_legacy();
        logic [31:0] d;
        core_msi_en = 1'b0;
        pulse();
        chk("R4 req low", {31'd0, irq_req_n}, 32'd0);
        chk("R4 assert flag low", {31'd0, irq_assert_n}, 32'd0);
        repeat (3) tick();
        chk("R4 held without ready", {30'd0, irq_req_n, irq_assert_n}, 32'd0);
        handshake();
        chk("R8 released after assert hs", {31'd0, irq_req_n}, 32'd1);
        repeat (4) tick();
        chk("R5 no deassert without clear", {31'd0, irq_req_n}, 32'd1);
        wr(7'd18, 32'h0000_013C);
        rd(7'd18, d);
        chk("R2 clear bit set", d, 32'h0000_013C);
        tick();
        chk("R5 deassert req", {30'd0, irq_req_n, irq_assert_n}, 32'd1);
        handshake();
        chk("R8 released after deassert", {31'd0, irq_req_n}, 32'd1);
        rd(7'd18, d);
        chk("R6 clear self-cleared", d, 32'h0000_003C);
        repeat (3) tick();
        chk("R5 no extra request", {31'd0, irq_req_n}, 32'd1);
    endtask

    task automatic t_msi();
        wr(7'd18, 32'h0000_00A5);
        core_msi_en = 1'b1;
        pulse();
        chk("R7 msi req", {30'd0, irq_req_n, irq_assert_n}, 32'd1);
        chk("R7 msi data", {24'd0, irq_data}, 32'h0000_00A5);
        handshake();
        chk("R8 msi released", {31'd0, irq_req_n}, 32'd1);
        repeat (4) tick();
        chk("R7 single request", {31'd0, irq_req_n}, 32'd1);
        core_msi_en = 1'b0;
    endtask

    task automatic t_pending();
        pulse();
        handshake();
        pulse();
        chk("R9 busy event no req", {31'd0, irq_req_n}, 32'd1);
        wr(7'd18, 32'h0000_0100);
        tick();
        chk("R5 deassert req (pend)", {30'd0, irq_req_n, irq_assert_n}, 32'd1);
        handshake();
        chk("R8 gap before pending", {31'd0, irq_req_n}, 32'd1);
        tick();
        chk("R9 pending serviced", {30'd0, irq_req_n, irq_assert_n}, 32'd0);
        handshake();
        wr(7'd18, 32'h0000_0100);
        tick();
        handshake();
        repeat (3) tick();
        chk("R9 pending consumed once", {31'd0, irq_req_n}, 32'd1);
    endtask

    task automatic t_layout();
        logic [31:0] d;
        core_vec_out = 8'h3C; core_mm_en = 3'd5; core_msi_en = 1'b1;
        wr(7'd18, 32'h0000_015A);
        rd(7'd18, d);
        chk("R3 field layout", d, 32'h0D3C_015A);
        core_msi_en = 1'b0; core_mm_en = 3'd2; core_vec_out = 8'h81;
        rd(7'd18, d);
        chk("R3 field layout 2", d, 32'h0281_015A);
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_regs();
        t_legacy();
        t_msi();
        t_pending();
        t_layout();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule